// File: doc/BRIEF.md
# Packed Integer Sign-Extension Unit

This block is one slice of a SIMD execution unit. It takes the lowest elements of a packed source vector and widens each one, with its sign bit copied upward, into a wider lane of a 128-bit or 256-bit result. A single opcode byte chooses one of six widening ratios. All six ratios share one datapath, built from two 128-bit halves.

The issue stage presents a set of inputs with `valid_in`:
- the low 128 bits of the source register;
- the old 256-bit destination value;
- the opcode;
- an encoding-class flag (legacy or extended prefix);
- a length flag;
- a spare 4-bit register-specifier field.

One cycle later the unit returns the result with `valid_out`, plus either a write enable or an illegal-instruction fault. The encoding class decides the upper 128 bits of a narrow result. The legacy class keeps the old destination bits. The short extended form forces them to zero. The long form computes them from the next source chunk.

Top module: `sxt_widen_unit`

## Requirements
- R1: Opcode 0x20 selects byte-to-word, 0x21 byte-to-dword, 0x22 byte-to-qword, 0x23 word-to-dword, 0x24 word-to-qword and 0x25 dword-to-qword. Any other opcode raises `illegal`.
- R2: In byte-to-word mode, result lane i (16 bits, lane 0 least significant) is source byte i with its sign extended, for example result[31:16] from src[15:8].
- R3: In byte-to-dword and byte-to-qword modes, each 32-bit or 64-bit lane i holds the sign-extended source byte i.
- R4: In word-to-dword and word-to-qword modes, each 32-bit or 64-bit lane i holds the sign-extended 16-bit source element i.
- R5: In dword-to-qword mode, each 64-bit lane i holds the sign-extended 32-bit source element i.
- R6: With `ext_prefix`=1 and `wide`=1, result[255:128] is computed from the source chunk directly above the one used for result[127:0]. For example, byte-to-word uses src[127:64], and byte-to-qword uses src[31:16].
- R7: With `ext_prefix`=0 and `wide`=0, result[255:128] equals the old destination bits 255:128.
- R8: With `ext_prefix`=1 and `wide`=0, result[255:128] is zero.
- R9: With `ext_prefix`=1, `spec_field` must be 4'b1111, and any other value raises `illegal`. With `ext_prefix`=0 the field has no effect.
- R10: `ext_prefix`=0 together with `wide`=1 raises `illegal`.
- R11: On a fault, `wr_en` is 0 and `result` equals the old destination value. On a legal operation, `wr_en` is 1 and `illegal` is 0.
- R12: `valid_out` follows `valid_in` by exactly one cycle. A cycle without `valid_in` gives `valid_out`, `wr_en` and `illegal` low in the next cycle, and `result` keeps its last value.
- R13: After reset, `valid_out`, `wr_en`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Operation present this cycle |
| opcode | input | 8 | Widening-mode opcode byte |
| ext_prefix | input | 1 | 1 = extended-prefix class, 0 = legacy class |
| wide | input | 1 | 1 = 256-bit result, 0 = 128-bit result |
| spec_field | input | 4 | Spare register specifier, must be all ones in the extended class |
| src | input | 128 | Low half of the source vector |
| old_dst | input | 256 | Previous destination value |
| valid_out | output | 1 | Result valid, one cycle after valid_in |
| result | output | 256 | Widened or merged destination value |
| wr_en | output | 1 | Destination write enable |
| illegal | output | 1 | Illegal-instruction fault |

## Verification
The bound checker checks these rules on every cycle:
- the one-cycle valid timing;
- that a write enable and a fault never occur together;
- the fault conditions raised by the opcode range, the specifier field and the legacy-wide combination;
- the merged or zeroed upper half for narrow forms;
- the lane-1 byte-to-word placement.

The bench's scenarios show that the lane contents are correct for every ratio, in both halves and with negative and positive elements. The scenarios also cover the chunk offset for the upper half in the long form and the result held across idle cycles.

// File: rtl/sxt_pkg.sv
package sxt_pkg;

    localparam int unsigned HALF_BITS = 128;
    localparam int unsigned NUM_MODES = 6;
    localparam int unsigned SPEC_W    = 4;
    localparam logic [7:0]  OPC_BASE  = 8'h20;

    typedef enum logic [2:0] {
        M_B2W = 3'd0,
        M_B2D = 3'd1,
        M_B2Q = 3'd2,
        M_W2D = 3'd3,
        M_W2Q = 3'd4,
        M_D2Q = 3'd5
    } sxt_mode_e;

    // narrow element width for mode index m
    function automatic int unsigned elem_in_w(input int unsigned m);
        case (m)
            0, 1, 2: return 8;
            3, 4:    return 16;
            default: return 32;
        endcase
    endfunction

    // widened lane width for mode index m
    function automatic int unsigned elem_out_w(input int unsigned m);
        case (m)
            0:       return 16;
            1, 3:    return 32;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/sxt_decode.sv
module sxt_decode
    import sxt_pkg::*;
#(
    parameter int unsigned SW_BITS = SPEC_W
) (
    input  logic [7:0]         opcode,
    input  logic               ext_prefix,
    input  logic               wide,
    input  logic [SW_BITS-1:0] spec_field,
    output sxt_mode_e          mode,
    output logic               fault
);
    localparam logic [7:0] OPC_LAST = OPC_BASE + 8'(NUM_MODES - 1);

    logic       op_ok;
    logic [7:0] op_off;

    always_comb begin
        op_ok  = (opcode >= OPC_BASE) && (opcode <= OPC_LAST);
        op_off = opcode - OPC_BASE;
        mode   = op_ok ? sxt_mode_e'(op_off[2:0]) : M_B2W;
        fault  = !op_ok
               || (ext_prefix && (spec_field != {SW_BITS{1'b1}}))
               || (!ext_prefix && wide);
    end
endmodule

// File: rtl/sxt_lanes.sv
module sxt_lanes #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned OUT_W = 16,
    parameter int unsigned COUNT = 8
) (
    input  logic [IN_W*COUNT-1:0]  x,
    output logic [OUT_W*COUNT-1:0] y
);
    localparam int unsigned PAD = OUT_W - IN_W;

    for (genvar i = 0; i < COUNT; i++) begin : g_lane
        assign y[i*OUT_W +: OUT_W] = {{PAD{x[i*IN_W+IN_W-1]}}, x[i*IN_W +: IN_W]};
    end
endmodule

// File: rtl/sxt_half.sv
module sxt_half
    import sxt_pkg::*;
#(
    parameter int unsigned HB      = HALF_BITS,
    parameter int unsigned HALF_IX = 0
) (
    input  logic [HB-1:0] src,
    input  sxt_mode_e     mode,
    output logic [HB-1:0] y
);
    logic [NUM_MODES-1:0][HB-1:0] cand;

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        localparam int unsigned IW    = elem_in_w(m);
        localparam int unsigned OW    = elem_out_w(m);
        localparam int unsigned CNT   = HB / OW;
        localparam int unsigned CHUNK = CNT * IW;
        logic [CHUNK-1:0] win;
        assign win = src[HALF_IX*CHUNK +: CHUNK];
        sxt_lanes #(.IN_W(IW), .OUT_W(OW), .COUNT(CNT)) u_lanes (
            .x(win),
            .y(cand[m])
        );
    end

    always_comb y = cand[mode];
endmodule

// File: rtl/sxt_widen_unit.sv
module sxt_widen_unit
    import sxt_pkg::*;
#(
    parameter int unsigned HB = HALF_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_in,
    input  logic [7:0]      opcode,
    input  logic            ext_prefix,
    input  logic            wide,
    input  logic [3:0]      spec_field,
    input  logic [HB-1:0]   src,
    input  logic [2*HB-1:0] old_dst,
    output logic            valid_out,
    output logic [2*HB-1:0] result,
    output logic            wr_en,
    output logic            illegal
);
    localparam int unsigned VW = 2 * HB;

    typedef struct packed {
        logic          valid;
        logic          wr_en;
        logic          illegal;
        logic [VW-1:0] data;
    } out_t;

    sxt_mode_e     mode;
    logic          fault;
    logic [HB-1:0] lo_half;
    logic [HB-1:0] hi_half;
    out_t          out_d, out_q;

    sxt_decode #(.SW_BITS(4)) u_dec (
        .opcode    (opcode),
        .ext_prefix(ext_prefix),
        .wide      (wide),
        .spec_field(spec_field),
        .mode      (mode),
        .fault     (fault)
    );

    sxt_half #(.HB(HB), .HALF_IX(0)) u_lo (.src(src), .mode(mode), .y(lo_half));
    sxt_half #(.HB(HB), .HALF_IX(1)) u_hi (.src(src), .mode(mode), .y(hi_half));

    always_comb begin
        out_d       = out_q;
        out_d.valid = valid_in;
        out_d.wr_en   = 1'b0;
        out_d.illegal = 1'b0;
        if (valid_in) begin
            out_d.illegal = fault;
            out_d.wr_en   = !fault;
            if (fault) begin
                out_d.data = old_dst;
            end else begin
                out_d.data[HB-1:0] = lo_half;
                if (wide)
                    out_d.data[VW-1:HB] = hi_half;
                else if (ext_prefix)
                    out_d.data[VW-1:HB] = '0;
                else
                    out_d.data[VW-1:HB] = old_dst[VW-1:HB];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_out = out_q.valid;
    assign wr_en     = out_q.wr_en;
    assign illegal   = out_q.illegal;
    assign result    = out_q.data;
endmodule

// File: rtl/sxt_widen_chk.sv
module sxt_widen_chk #(
    parameter int unsigned HB = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid_in,
    input logic [7:0]      opcode,
    input logic            ext_prefix,
    input logic            wide,
    input logic [3:0]      spec_field,
    input logic [HB-1:0]   src,
    input logic [2*HB-1:0] old_dst,
    input logic            valid_out,
    input logic [2*HB-1:0] result,
    input logic            wr_en,
    input logic            illegal
);
    logic op_in_range;
    logic legal_in;
    assign op_in_range = (opcode >= 8'h20) && (opcode <= 8'h25);
    assign legal_in    = op_in_range && (ext_prefix ? (spec_field == 4'hF) : !wide);

    p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!valid_out && !wr_en && !illegal));
    p_we_xor_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && illegal));
    p_fault_keeps_dst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !legal_in) |=> (illegal && !wr_en && result == $past(old_dst)));
    p_bad_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !op_in_range) |=> illegal);
    p_spec_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && ext_prefix && spec_field != 4'hF) |=> illegal);
    p_legacy_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !ext_prefix && wide) |=> illegal);
    p_legacy_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && legal_in && !ext_prefix && !wide)
            |=> (wr_en && result[2*HB-1:HB] == $past(old_dst[2*HB-1:HB])));
    p_ext_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && legal_in && ext_prefix && !wide)
            |=> (wr_en && result[2*HB-1:HB] == '0));
    p_b2w_lane1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && legal_in && opcode == 8'h20)
            |=> (result[31:16] == {{8{$past(src[15])}}, $past(src[15:8])}));
endmodule

bind sxt_widen_unit sxt_widen_chk #(.HB(HB)) u_chk (.*);

// File: tb/sim_sxt_widen_unit.sv
`timescale 1ns/1ps
module sim_sxt_widen_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [7:0]   opcode = 8'h00;
    logic         ext_prefix = 1'b0;
    logic         wide = 1'b0;
    logic [3:0]   spec_field = 4'h0;
    logic [127:0] src = '0;
    logic [255:0] old_dst = '0;
    logic         valid_out;
    logic [255:0] result;
    logic         wr_en;
    logic         illegal;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sxt_widen_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .opcode(opcode),
        .ext_prefix(ext_prefix), .wide(wide), .spec_field(spec_field),
        .src(src), .old_dst(old_dst), .valid_out(valid_out), .result(result),
        .wr_en(wr_en), .illegal(illegal)
    );

    function automatic bit exp_fault(input logic [7:0] op, input logic e,
                                     input logic w, input logic [3:0] s);
        return (op < 8'h20) || (op > 8'h25) || (e && s != 4'hF) || (!e && w);
    endfunction

    function automatic logic [255:0] exp_result(input logic [7:0] op, input logic e,
            input logic w, input logic [3:0] s, input logic [127:0] sv,
            input logic [255:0] od);
        logic [255:0] r;
        int iw, ow, n, k;
        if (exp_fault(op, e, w, s)) return od;
        case (op)
            8'h20: begin iw = 8;  ow = 16; end
            8'h21: begin iw = 8;  ow = 32; end
            8'h22: begin iw = 8;  ow = 64; end
            8'h23: begin iw = 16; ow = 32; end
            8'h24: begin iw = 16; ow = 64; end
            default: begin iw = 32; ow = 64; end
        endcase
        n = 128 / ow;
        r = w ? '0 : (e ? '0 : {od[255:128], 128'h0});
        for (int h = 0; h < (w ? 2 : 1); h++) begin
            for (int i = 0; i < n; i++) begin
                k = h * n + i;
                for (int b = 0; b < ow; b++)
                    r[h*128 + i*ow + b] = (b < iw) ? sv[k*iw + b] : sv[k*iw + iw - 1];
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [255:0] act,
                         input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one operation, check outputs one cycle later
    task automatic run_op(input string tag, input logic [7:0] op, input logic e,
                          input logic w, input logic [3:0] s,
                          input logic [127:0] sv, input logic [255:0] od);
        logic [255:0] er;
        bit ef;
        @(negedge clk);
        valid_in = 1'b1; opcode = op; ext_prefix = e; wide = w;
        spec_field = s; src = sv; old_dst = od;
        er = exp_result(op, e, w, s, sv, od);
        ef = exp_fault(op, e, w, s);
        @(negedge clk);
        valid_in = 1'b0;
        check(result == er, {tag, " result"}, result, er);
        check(valid_out && illegal == ef && wr_en == !ef, {tag, " flags"},
              {253'h0, valid_out, illegal, wr_en}, {253'h0, 1'b1, ef, !ef});
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic t_reset();
        check(!valid_out && !wr_en && !illegal && result == '0, "R13 reset state",
              result, '0);
    endtask

    task automatic t_b2w();
        run_op("R2 b2w mixed", 8'h20, 1'b1, 1'b0, 4'hF, 128'h0123_4567_89AB_CDEF_807F_01FF_8000_7F80, '1);
        run_op("R2 b2w legacy", 8'h20, 1'b0, 1'b0, 4'h3, rnd128(), {rnd128(), rnd128()});
    endtask

    task automatic t_b2d_b2q();
        run_op("R3 b2d", 8'h21, 1'b1, 1'b0, 4'hF, 128'h0000_0000_0000_0000_0000_0000_80FF_7F01, '0);
        run_op("R3 b2q", 8'h22, 1'b1, 1'b0, 4'hF, rnd128(), '0);
    endtask

    task automatic t_w2x();
        run_op("R4 w2d", 8'h23, 1'b1, 1'b0, 4'hF, 128'h0000_0000_0000_0000_8000_7FFF_FFFF_0001, '0);
        run_op("R4 w2q", 8'h24, 1'b0, 1'b0, 4'h0, rnd128(), {rnd128(), rnd128()});
    endtask

    task automatic t_d2q();
        run_op("R5 d2q", 8'h25, 1'b1, 1'b0, 4'hF, 128'h0000_0000_0000_0000_8000_0001_7FFF_FFFF, '1);
    endtask

    task automatic t_wide();
        for (int m = 0; m < 6; m++)
            run_op("R6 wide form", 8'h20 + 8'(m), 1'b1, 1'b1, 4'hF, rnd128(), {rnd128(), rnd128()});
        run_op("R6 b2q upper chunk", 8'h22, 1'b1, 1'b1, 4'hF, 128'h0000_0000_0000_0000_0000_0000_7F80_0000, '1);
    endtask

    task automatic t_narrow_upper();
        run_op("R7 legacy keeps upper", 8'h21, 1'b0, 1'b0, 4'h5, rnd128(), {128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, rnd128()});
        run_op("R8 ext zero upper", 8'h23, 1'b1, 1'b0, 4'hF, rnd128(), '1);
    endtask

    task automatic t_faults();
        run_op("R9 spec not ones", 8'h20, 1'b1, 1'b0, 4'hE, rnd128(), {rnd128(), rnd128()});
        run_op("R9 spec zero wide", 8'h25, 1'b1, 1'b1, 4'h0, rnd128(), {rnd128(), rnd128()});
        run_op("R10 legacy wide", 8'h20, 1'b0, 1'b1, 4'hF, rnd128(), {rnd128(), rnd128()});
        run_op("R1 opcode 0x26", 8'h26, 1'b1, 1'b0, 4'hF, rnd128(), {rnd128(), rnd128()});
        run_op("R1 opcode 0x1F", 8'h1F, 1'b0, 1'b0, 4'hF, rnd128(), {rnd128(), rnd128()});
        run_op("R11 fault keeps old", 8'hFF, 1'b1, 1'b1, 4'h1, rnd128(), '1);
    endtask

    task automatic t_idle();
        logic [255:0] held;
        run_op("R12 before idle", 8'h24, 1'b1, 1'b0, 4'hF, rnd128(), '0);
        held = result;
        @(negedge clk);
        opcode = 8'h20; src = rnd128();
        @(negedge clk);
        check(!valid_out && !wr_en && !illegal, "R12 idle flags low",
              {253'h0, valid_out, wr_en, illegal}, '0);
        check(result == held, "R12 result held", result, held);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog timeout actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_b2w();
        t_b2d_b2q();
        t_w2x();
        t_d2q();
        t_wide();
        t_narrow_upper();
        t_faults();
        t_idle();
        for (int j = 0; j < 40; j++)
            run_op("R1 mixed sweep", 8'h1E + 8'($urandom_range(0, 9)), 1'($urandom),
                   1'($urandom), 4'($urandom_range(14, 15)), rnd128(), {rnd128(), rnd128()});
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule